// File: doc/BRIEF.md
# Bridge Legacy I/O Forwarding Decoder

This block sits in a root-port-style bridge and decides, for every I/O transaction issued by the processor, whether the bridge passes it to the downstream port. The decision combines the programmed I/O base/limit window with two legacy behaviours. One is ISA alias exclusion, which drops the upper 768 bytes of every 1 KB block inside the window. The other is VGA I/O claiming, which can match only the low 10 address bits or all 16. The decision is registered and appears one cycle after a valid request.

The same block holds the 16-bit bridge control register that steers these behaviours. Through a small configuration read/write port, software also uses it to request a hot reset of the downstream port and to gate error messages received from downstream into an SERR indication. The enables for each error class come from outside as inputs.

Top module: `io_fwd_bridge`

## Requirements
- R1: After reset the control register reads 0000h at configuration offset 3Eh, and fwd_o, serr_o, hot_rst_req_o and hot_rst_pulse_o are low.
- R2: Bit 5 and bits 15:7 always read 0 and ignore writes, and a write to any offset other than 3Eh leaves the register unchanged. A read at another offset returns 0.
- R3: Bits 0 (parity response), 1 (SERR enable), 2 (ISA enable), 3 (VGA enable), 4 (VGA 16-bit decode) and 6 (hot reset) are read/write and read back what was written.
- R4: hot_rst_req_o is high while bit 6 is set. hot_rst_pulse_o is high for exactly one cycle, in the cycle in which bit 6 changes from 0 to 1.
- R5: With bit 2 clear, a request is forwarded when io_base_i <= req_addr_i[15:12] <= io_limit_i. If base > limit, the window is empty.
- R6: With bit 2 set, an in-window address with req_addr_i[9:8] != 00 is not forwarded. Addresses outside the window are never added by this rule.
- R7: With bit 3 set and bit 4 clear, an address whose bits [9:0] fall in 3B0h–3BBh or 3C0h–3DFh is forwarded, so the ranges alias every 1 KB.
- R8: With bits 3 and 4 set, the VGA match also requires req_addr_i[15:10] = 0. A VGA match forwards the request even when the window or ISA exclusion rejects it.
- R9: Bit 4 has no effect while bit 3 is clear.
- R10: serr_o rises one cycle after an error pulse on err_msg_i (bit 0 correctable, bit 1 non-fatal, bit 2 fatal), but only if bit 1 is set and the matching err_cls_en_i bit is set.
- R11: fwd_o reflects a request one cycle after req_valid_i and is low when no request was valid. A configuration write applies to a request presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration offset |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration read data |
| io_base_i | input | 4 | I/O window base, 4 KB units |
| io_limit_i | input | 4 | I/O window limit, 4 KB units |
| req_valid_i | input | 1 | I/O request valid |
| req_addr_i | input | 16 | I/O request address |
| fwd_o | output | 1 | Forward decision for previous cycle's request |
| hot_rst_req_o | output | 1 | Downstream hot reset request level |
| hot_rst_pulse_o | output | 1 | One-cycle pulse when hot reset is requested |
| err_msg_i | input | 3 | Received error messages: cor, non-fatal, fatal |
| err_cls_en_i | input | 3 | Per-class error forwarding enables |
| serr_o | output | 1 | Registered SERR indication |

## Verification
The bench builds the block with its default parameters: a 16-bit I/O address, 4 KB window granularity, three error classes and the control register at offset 3Eh. With these values every window edge can be reached with a handful of addresses: the first and last byte of a 4 KB page, and the 10-bit VGA aliases above 3FFh. The same holds for the 1 KB boundary where ISA exclusion switches on and off. An empty window (base above limit) separates VGA claiming from window claiming.

// File: rtl/iob_pkg.sv
package iob_pkg;
  localparam int CTRL_W   = 16;
  localparam int B_PERR   = 0;
  localparam int B_SERR   = 1;
  localparam int B_ISA    = 2;
  localparam int B_VGA    = 3;
  localparam int B_VGA16  = 4;
  localparam int B_HRST   = 6;
  localparam logic [CTRL_W-1:0] RW_MASK = 16'h005F;
  localparam logic [9:0] VGA_A_LO = 10'h3B0;
  localparam logic [9:0] VGA_A_HI = 10'h3BB;
  localparam logic [9:0] VGA_B_LO = 10'h3C0;
  localparam logic [9:0] VGA_B_HI = 10'h3DF;
endpackage

// File: rtl/iob_ctrl_reg.sv
module iob_ctrl_reg
  import iob_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CTRL_OFS = 8'h3E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              hot_rst_pulse_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              hit, wr;

  assign hit = (cfg_addr_i == CTRL_OFS);
  assign wr  = cfg_we_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q          <= '0;
      hot_rst_pulse_o <= 1'b0;
    end else begin
      hot_rst_pulse_o <= wr && cfg_wdata_i[B_HRST] && !ctrl_q[B_HRST];
      if (wr) ctrl_q <= cfg_wdata_i & RW_MASK;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign cfg_rdata_o = hit ? ctrl_q : '0;

  p_wr_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> ctrl_q == ($past(cfg_wdata_i) & RW_MASK));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(ctrl_q));
  p_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_rst_pulse_o |-> ctrl_q[B_HRST]);
  p_pulse_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_rst_pulse_o |=> !hot_rst_pulse_o || !$stable(ctrl_q));
endmodule

// File: rtl/iob_io_decode.sv
module iob_io_decode
  import iob_pkg::*;
#(
  parameter int IO_AW   = 16,
  parameter int WIN_LSB = 12,
  localparam int WIN_W  = IO_AW - WIN_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             isa_en_i,
  input  logic             vga_en_i,
  input  logic             vga16_i,
  input  logic [WIN_W-1:0] base_i,
  input  logic [WIN_W-1:0] limit_i,
  input  logic             req_valid_i,
  input  logic [IO_AW-1:0] req_addr_i,
  output logic             fwd_o
);
  logic [WIN_W-1:0] page;
  logic [9:0]       low10;
  logic             in_win, isa_drop, vga_rng, vga_hi_ok, vga_hit, claim;

  assign page   = req_addr_i[IO_AW-1:WIN_LSB];
  assign low10  = req_addr_i[9:0];
  assign in_win = (page >= base_i) && (page <= limit_i);
  // upper 768 bytes of each 1 KB block
  assign isa_drop = isa_en_i && (req_addr_i[9:8] != 2'b00);

  assign vga_rng   = ((low10 >= VGA_A_LO) && (low10 <= VGA_A_HI)) ||
                     ((low10 >= VGA_B_LO) && (low10 <= VGA_B_HI));
  assign vga_hi_ok = !vga16_i || (req_addr_i[IO_AW-1:10] == '0);
  assign vga_hit   = vga_en_i && vga_rng && vga_hi_ok;

  assign claim = vga_hit || (in_win && !isa_drop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_o <= 1'b0;
    else         fwd_o <= req_valid_i && claim;
  end

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !fwd_o);
  p_empty_win_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !vga_en_i && (base_i > limit_i)) |=> !fwd_o);
  p_isa_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !vga_en_i && isa_en_i && req_addr_i[9:8] != 2'b00) |=> !fwd_o);
endmodule

// File: rtl/iob_err_gate.sv
module iob_err_gate #(
  parameter int NERR = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            serr_en_i,
  input  logic [NERR-1:0] err_msg_i,
  input  logic [NERR-1:0] err_cls_en_i,
  output logic            serr_o
);
  logic [NERR-1:0] pass;

  for (genvar g = 0; g < NERR; g++) begin : g_cls
    assign pass[g] = err_msg_i[g] && err_cls_en_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_o <= 1'b0;
    else         serr_o <= serr_en_i && (|pass);
  end

  p_serr_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_en_i |=> !serr_o);
  p_serr_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_msg_i & err_cls_en_i) == '0) |=> !serr_o);
endmodule

// File: rtl/io_fwd_bridge.sv
module io_fwd_bridge
  import iob_pkg::*;
#(
  parameter int CFG_AW  = 8,
  parameter logic [CFG_AW-1:0] CTRL_OFS = 8'h3E,
  parameter int IO_AW   = 16,
  parameter int WIN_LSB = 12,
  parameter int NERR    = 3,
  localparam int WIN_W  = IO_AW - WIN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  input  logic [WIN_W-1:0]  io_base_i,
  input  logic [WIN_W-1:0]  io_limit_i,
  input  logic              req_valid_i,
  input  logic [IO_AW-1:0]  req_addr_i,
  output logic              fwd_o,
  output logic              hot_rst_req_o,
  output logic              hot_rst_pulse_o,
  input  logic [NERR-1:0]   err_msg_i,
  input  logic [NERR-1:0]   err_cls_en_i,
  output logic              serr_o
);
  logic [CTRL_W-1:0] ctrl;

  iob_ctrl_reg #(.CFG_AW(CFG_AW), .CTRL_OFS(CTRL_OFS)) i_ctrl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .ctrl_o(ctrl), .hot_rst_pulse_o
  );

  iob_io_decode #(.IO_AW(IO_AW), .WIN_LSB(WIN_LSB)) i_dec (
    .clk_i, .rst_ni,
    .isa_en_i(ctrl[B_ISA]), .vga_en_i(ctrl[B_VGA]), .vga16_i(ctrl[B_VGA16]),
    .base_i(io_base_i), .limit_i(io_limit_i),
    .req_valid_i, .req_addr_i, .fwd_o
  );

  iob_err_gate #(.NERR(NERR)) i_err (
    .clk_i, .rst_ni, .serr_en_i(ctrl[B_SERR]),
    .err_msg_i, .err_cls_en_i, .serr_o
  );

  assign hot_rst_req_o = ctrl[B_HRST];

  p_rst_lvl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hot_rst_req_o) |-> hot_rst_pulse_o);
endmodule

// File: tb/test_io_fwd_bridge.sv
`timescale 1ns/1ps
module test_io_fwd_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = 8'h3E;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic [3:0]  io_base_i = 4'h1, io_limit_i = 4'h2;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic        fwd_o, hot_rst_req_o, hot_rst_pulse_o, serr_o;
  logic [2:0]  err_msg_i = '0, err_cls_en_i = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  io_fwd_bridge i_io_fwd_bridge (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk_i);
    cfg_addr_i = a; cfg_wdata_i = d; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_addr_i = 8'h3E;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [15:0] exp);
    cfg_addr_i = a; #0.5;
    chk(req, cfg_rdata_o, exp);
    cfg_addr_i = 8'h3E;
  endtask

  // presents request at a negedge, checks fwd_o at the next negedge
  task automatic rq(string req, logic [15:0] a, logic exp);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req, {15'b0, fwd_o}, {15'b0, exp});
  endtask

  task automatic t_reset;
    rd("R1", 8'h3E, 16'h0000);
    chk("R1", {12'b0, fwd_o, serr_o, hot_rst_req_o, hot_rst_pulse_o}, 16'h0);
  endtask

  task automatic t_regs;
    wr(8'h3E, 16'hFFBF);
    rd("R2", 8'h3E, 16'h001F);
    rd("R2", 8'h20, 16'h0000);
    wr(8'h3C, 16'h0000);
    rd("R2", 8'h3E, 16'h001F);
    wr(8'h3E, 16'h0015);
    rd("R3", 8'h3E, 16'h0015);
    wr(8'h3E, 16'h0000);
  endtask

  task automatic t_hot;
    @(negedge clk_i);
    cfg_wdata_i = 16'h0040; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R4", {14'b0, hot_rst_req_o, hot_rst_pulse_o}, 16'h3);
    @(negedge clk_i);
    chk("R4", {14'b0, hot_rst_req_o, hot_rst_pulse_o}, 16'h2);
    wr(8'h3E, 16'h0040);
    chk("R4", {14'b0, hot_rst_req_o, hot_rst_pulse_o}, 16'h2);
    wr(8'h3E, 16'h0000);
    chk("R4", {14'b0, hot_rst_req_o, hot_rst_pulse_o}, 16'h0);
  endtask

  task automatic t_window;
    io_base_i = 4'h1; io_limit_i = 4'h2;
    rq("R5", 16'h1000, 1'b1);
    rq("R5", 16'h2FFF, 1'b1);
    rq("R5", 16'h3000, 1'b0);
    rq("R5", 16'h0FFF, 1'b0);
    io_base_i = 4'h3;
    rq("R5", 16'h2100, 1'b0);
    io_base_i = 4'h1;
  endtask

  task automatic t_isa;
    wr(8'h3E, 16'h0004);
    rq("R11", 16'h1100, 1'b0); // applies to request right after write
    rq("R6", 16'h1000, 1'b1);
    rq("R6", 16'h13FF, 1'b0);
    rq("R6", 16'h14FF, 1'b1);
    rq("R6", 16'h3000, 1'b0);
    wr(8'h3E, 16'h0000);
  endtask

  task automatic t_vga;
    io_base_i = 4'hF; io_limit_i = 4'h0;
    rq("R9", 16'h03C5, 1'b0);
    wr(8'h3E, 16'h0010);
    rq("R9", 16'h03C5, 1'b0);
    wr(8'h3E, 16'h0008);
    rq("R7", 16'h03B0, 1'b1);
    rq("R7", 16'h03BB, 1'b1);
    rq("R7", 16'h03BC, 1'b0);
    rq("R7", 16'h03DF, 1'b1);
    rq("R7", 16'h03E0, 1'b0);
    rq("R7", 16'h07C0, 1'b1);
    rq("R7", 16'hABB5, 1'b1);
    wr(8'h3E, 16'h0018);
    rq("R8", 16'h07C0, 1'b0);
    rq("R8", 16'h03C5, 1'b1);
    io_base_i = 4'h0; io_limit_i = 4'h0;
    wr(8'h3E, 16'h001C);
    rq("R8", 16'h03C0, 1'b1);
    rq("R8", 16'h0300, 1'b0);
    wr(8'h3E, 16'h0000);
  endtask

  task automatic t_idle;
    io_base_i = 4'h1; io_limit_i = 4'h2;
    req_addr_i = 16'h1000;
    @(negedge clk_i);
    chk("R11", {15'b0, fwd_o}, 16'h0);
  endtask

  task automatic t_serr;
    err_cls_en_i = 3'b101;
    err_msg_i = 3'b111;
    @(negedge clk_i); err_msg_i = '0;
    chk("R10", {15'b0, serr_o}, 16'h0);
    wr(8'h3E, 16'h0002);
    err_msg_i = 3'b001;
    @(negedge clk_i); err_msg_i = '0;
    chk("R10", {15'b0, serr_o}, 16'h1);
    err_msg_i = 3'b010;
    @(negedge clk_i); err_msg_i = '0;
    chk("R10", {15'b0, serr_o}, 16'h0);
    err_msg_i = 3'b100;
    @(negedge clk_i); err_msg_i = '0;
    chk("R10", {15'b0, serr_o}, 16'h1);
    @(negedge clk_i);
    chk("R10", {15'b0, serr_o}, 16'h0);
    wr(8'h3E, 16'h0000);
  endtask

  initial begin
    #1;
    t_reset;
    #11 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_regs;
    t_hot;
    t_window;
    t_isa;
    t_vga;
    t_idle;
    t_serr;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule